// File: doc/BRIEF.md
# Host-Loadable Output Flip-Flop Bank

This block holds sixteen output flip-flops split into two groups of eight. In normal operation each flip-flop is steered by signals from the surrounding programmable logic: a data bit, a clock enable, a set input and a clear input, all sampled on the shared clock. A host processor sees each group as a single byte register in its peripheral window. The group at offset 20h holds cells 0 to 7 and the group at offset 21h holds cells 8 to 15. Writing a byte replaces the whole group, whatever the logic side asks for in that cycle. Reading a byte returns the group's current state.

The bank has two reset inputs. Power-on reset clears every flip-flop. Warm reset leaves the flip-flops alone and only clears the registered read-data output. A per-cell enable mask gates the flip-flop states onto the pin outputs, so that pins reserved for other uses are held low.

Top module: `macrocell_bank`

## Requirements
- R1: While `por_n` is low, all sixteen bits of `cell_q` and all of `pin_out` are 0. The clear is asynchronous.
- R2: While `warm_rst_n` is low, `cell_q` does not change unless the logic side or the host acts, and `host_rdata` is 00h.
- R3: A host write (`host_wr` high) to offset 20h loads `host_wdata` bit n into `cell_q[n]`. A host write to offset 21h loads bit n into `cell_q[8+n]`. The load takes effect at the next rising clock edge.
- R4: In the cycle of a host write to a group, that group's set, clear and clock-enable inputs are ignored. The other group keeps following its own logic-side inputs.
- R5: With no host write to its group, a cell whose `lg_set` bit is high becomes 1, even when its clear bit is also high.
- R6: With no host write and `lg_set` low, a cell whose `lg_clr` bit is high becomes 0, even when its clock enable is high.
- R7: With no host write, set or clear, a cell whose `lg_en` bit is high captures its `lg_d` bit. A cell with none of these inputs active holds its value.
- R8: A read strobe (`host_rd` high) at offset 20h or 21h makes `host_rdata` equal that group's state after the next edge, with bit n taken from cell n of the group. The state used is the one before any update at that edge.
- R9: A read strobe at any other offset makes `host_rdata` 00h and leaves `cell_q` unchanged.
- R10: `pin_out[i]` equals `cell_q[i]` when `pin_oe[i]` is high, and is 0 when `pin_oe[i]` is low.
- R11: A host write to any offset other than 20h and 21h changes no cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the logic side and the host |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the cells |
| warm_rst_n | input | 1 | Warm reset, active low; clears only the read-data register |
| host_addr | input | 8 | Register offset of the host access |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered read byte |
| lg_d | input | 16 | Logic-side data, one bit per cell |
| lg_en | input | 16 | Logic-side clock enable, one bit per cell |
| lg_set | input | 16 | Logic-side set, one bit per cell |
| lg_clr | input | 16 | Logic-side clear, one bit per cell |
| pin_oe | input | 16 | Pin enable mask, one bit per cell |
| cell_q | output | 16 | Current state of the cells |
| pin_out | output | 16 | Cell states gated by the enable mask |

## Verification
The assertions assume that power-on reset is held low for at least one rising edge at start-up. They also assume that every logic-side and host input is a settled 0 or 1 at each edge, and that a group-specific check is only meaningful when the host address is stable over the cycle it samples. The bench drives all inputs on the falling clock edge and holds them for a full cycle. It returns every logic-side vector to zero between scenarios, so that each check sees only the controls that scenario applied.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

   typedef enum logic [2:0] {
      CELL_HOLD = 3'd0,
      CELL_LOAD = 3'd1,
      CELL_SET  = 3'd2,
      CELL_CLR  = 3'd3,
      CELL_CAPT = 3'd4
   } cell_act_e;

   // Host load beats set, set beats clear, clear beats a clocked capture.
   function automatic cell_act_e pick_action(input logic load, input logic set,
                                             input logic clr, input logic en);
      if (load)     return CELL_LOAD;
      else if (set) return CELL_SET;
      else if (clr) return CELL_CLR;
      else if (en)  return CELL_CAPT;
      else          return CELL_HOLD;
   endfunction

endpackage

// File: rtl/mcb_addr_dec.sv
module mcb_addr_dec #(
   parameter int ADDR_W      = 8,
   parameter int NUM_GROUPS  = 2,
   parameter int BASE_OFFSET = 32
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  wr,
   input  logic                  rd,
   output logic [NUM_GROUPS-1:0] grp_wr,
   output logic [NUM_GROUPS-1:0] grp_rd
);

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_match
         localparam logic [ADDR_W-1:0] GRP_OFFS = ADDR_W'(BASE_OFFSET + g);
         logic hit;
         assign hit       = (addr == GRP_OFFS);
         assign grp_wr[g] = wr & hit;
         assign grp_rd[g] = rd & hit;
      end
   endgenerate

endmodule

// File: rtl/mcb_cell_group.sv
module mcb_cell_group
   import mcb_pkg::*;
#(
   parameter int GROUP_W = 8
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               load,
   input  logic [GROUP_W-1:0] wdata,
   input  logic [GROUP_W-1:0] d,
   input  logic [GROUP_W-1:0] en,
   input  logic [GROUP_W-1:0] set,
   input  logic [GROUP_W-1:0] clr,
   output logic [GROUP_W-1:0] q
);

   generate
      for (genvar b = 0; b < GROUP_W; b++) begin : g_cell
         cell_act_e act;
         logic      q_r;

         always_comb act = pick_action(load, set[b], clr[b], en[b]);

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               q_r <= 1'b0;
            end else begin
               case (act)
                  CELL_LOAD: q_r <= wdata[b];
                  CELL_SET:  q_r <= 1'b1;
                  CELL_CLR:  q_r <= 1'b0;
                  CELL_CAPT: q_r <= d[b];
                  default:   q_r <= q_r;
               endcase
            end
         end

         assign q[b] = q_r;
      end
   endgenerate

endmodule

// File: rtl/mcb_read_port.sv
module mcb_read_port #(
   parameter int NUM_GROUPS = 2,
   parameter int GROUP_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd,
   input  logic [NUM_GROUPS-1:0]         grp_rd,
   input  logic [NUM_GROUPS*GROUP_W-1:0] q_all,
   output logic [GROUP_W-1:0]            rdata
);

   logic [GROUP_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (grp_rd[g]) rd_next = rd_next | q_all[g*GROUP_W +: GROUP_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_next;
   end

endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank #(
   parameter int ADDR_W      = 8,
   parameter int GROUP_W     = 8,
   parameter int NUM_GROUPS  = 2,
   parameter int BASE_OFFSET = 32,
   localparam int NCELL      = NUM_GROUPS * GROUP_W
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               warm_rst_n,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic               host_wr,
   input  logic [GROUP_W-1:0] host_wdata,
   input  logic               host_rd,
   output logic [GROUP_W-1:0] host_rdata,
   input  logic [NCELL-1:0]   lg_d,
   input  logic [NCELL-1:0]   lg_en,
   input  logic [NCELL-1:0]   lg_set,
   input  logic [NCELL-1:0]   lg_clr,
   input  logic [NCELL-1:0]   pin_oe,
   output logic [NCELL-1:0]   cell_q,
   output logic [NCELL-1:0]   pin_out
);

   generate
      if (GROUP_W < 1 || NUM_GROUPS < 1) begin : g_bad_shape
         $error("macrocell_bank: GROUP_W and NUM_GROUPS must be at least 1");
      end
      if (BASE_OFFSET < 0 || BASE_OFFSET + NUM_GROUPS > (1 << ADDR_W)) begin : g_bad_window
         $error("macrocell_bank: register window does not fit the address width");
      end
   endgenerate

   logic [NUM_GROUPS-1:0] grp_wr;
   logic [NUM_GROUPS-1:0] grp_rd;
   logic                  rd_rst_n;

   assign rd_rst_n = por_n & warm_rst_n;

   mcb_addr_dec #(
      .ADDR_W      (ADDR_W),
      .NUM_GROUPS  (NUM_GROUPS),
      .BASE_OFFSET (BASE_OFFSET)
   ) dec_i (
      .addr   (host_addr),
      .wr     (host_wr),
      .rd     (host_rd),
      .grp_wr (grp_wr),
      .grp_rd (grp_rd)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
         mcb_cell_group #(
            .GROUP_W (GROUP_W)
         ) grp_i (
            .clk   (clk),
            .por_n (por_n),
            .load  (grp_wr[g]),
            .wdata (host_wdata),
            .d     (lg_d  [g*GROUP_W +: GROUP_W]),
            .en    (lg_en [g*GROUP_W +: GROUP_W]),
            .set   (lg_set[g*GROUP_W +: GROUP_W]),
            .clr   (lg_clr[g*GROUP_W +: GROUP_W]),
            .q     (cell_q[g*GROUP_W +: GROUP_W])
         );
      end
   endgenerate

   mcb_read_port #(
      .NUM_GROUPS (NUM_GROUPS),
      .GROUP_W    (GROUP_W)
   ) rdp_i (
      .clk    (clk),
      .rst_n  (rd_rst_n),
      .rd     (host_rd),
      .grp_rd (grp_rd),
      .q_all  (cell_q),
      .rdata  (host_rdata)
   );

   assign pin_out = cell_q & pin_oe;

endmodule

// File: rtl/mcb_checker.sv
module mcb_checker #(
   parameter int ADDR_W      = 8,
   parameter int GROUP_W     = 8,
   parameter int NUM_GROUPS  = 2,
   parameter int BASE_OFFSET = 32,
   localparam int NCELL      = NUM_GROUPS * GROUP_W
) (
   input logic               clk,
   input logic               por_n,
   input logic [ADDR_W-1:0]  host_addr,
   input logic               host_wr,
   input logic [GROUP_W-1:0] host_wdata,
   input logic               host_rd,
   input logic [GROUP_W-1:0] host_rdata,
   input logic [NCELL-1:0]   lg_en,
   input logic [NCELL-1:0]   lg_set,
   input logic [NCELL-1:0]   lg_clr,
   input logic [NCELL-1:0]   cell_q
);

   logic in_window;
   assign in_window = (int'(host_addr) >= BASE_OFFSET) &&
                      (int'(host_addr) < BASE_OFFSET + NUM_GROUPS);

   // R1: power-on reset holds every cell at zero
   a_r1_por_clear: assert property (@(posedge clk) !por_n |-> (cell_q == '0));

   // R5: set forces a one when the host is not writing
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!por_n)
      !host_wr |=> ((cell_q & $past(lg_set)) == $past(lg_set)));

   // R6: clear forces a zero when neither host nor set acts
   a_r6_clear: assert property (@(posedge clk) disable iff (!por_n)
      !host_wr |=> ((cell_q & $past(lg_clr & ~lg_set)) == '0));

   // R7: idle cells hold
   a_r7_hold: assert property (@(posedge clk) disable iff (!por_n)
      !host_wr |=> (((cell_q ^ $past(cell_q)) & $past(~(lg_set | lg_clr | lg_en))) == '0));

   // R9: reads outside the window return zero
   a_r9_read_outside: assert property (@(posedge clk) disable iff (!por_n)
      (host_rd && !in_window) |=> (host_rdata == '0));

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         localparam logic [ADDR_W-1:0] GOFFS = ADDR_W'(BASE_OFFSET + g);

         // R3 and R4: a host write loads the group regardless of logic controls
         a_r3_group_load: assert property (@(posedge clk) disable iff (!por_n)
            (host_wr && host_addr == GOFFS) |=>
               (cell_q[g*GROUP_W +: GROUP_W] == $past(host_wdata)));

         // R11 and R4: a write elsewhere leaves a quiet group untouched
         a_r11_other_write: assert property (@(posedge clk) disable iff (!por_n)
            (host_wr && host_addr != GOFFS &&
             (lg_set[g*GROUP_W +: GROUP_W] | lg_clr[g*GROUP_W +: GROUP_W] |
              lg_en[g*GROUP_W +: GROUP_W]) == '0) |=>
               $stable(cell_q[g*GROUP_W +: GROUP_W]));
      end
   endgenerate

endmodule

bind macrocell_bank mcb_checker #(
   .ADDR_W      (ADDR_W),
   .GROUP_W     (GROUP_W),
   .NUM_GROUPS  (NUM_GROUPS),
   .BASE_OFFSET (BASE_OFFSET)
) chk_i (
   .clk        (clk),
   .por_n      (por_n),
   .host_addr  (host_addr),
   .host_wr    (host_wr),
   .host_wdata (host_wdata),
   .host_rd    (host_rd),
   .host_rdata (host_rdata),
   .lg_en      (lg_en),
   .lg_set     (lg_set),
   .lg_clr     (lg_clr),
   .cell_q     (cell_q)
);

// File: tb/macrocell_bank_tb.sv
module macrocell_bank_tb_top;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        warm_rst_n = 1'b1;
   logic [7:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_rdata;
   logic [15:0] lg_d = '0;
   logic [15:0] lg_en = '0;
   logic [15:0] lg_set = '0;
   logic [15:0] lg_clr = '0;
   logic [15:0] pin_oe = 16'hFFFF;
   logic [15:0] cell_q;
   logic [15:0] pin_out;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   macrocell_bank dut_i (
      .clk        (clk),
      .por_n      (por_n),
      .warm_rst_n (warm_rst_n),
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rd    (host_rd),
      .host_rdata (host_rdata),
      .lg_d       (lg_d),
      .lg_en      (lg_en),
      .lg_set     (lg_set),
      .lg_clr     (lg_clr),
      .pin_oe     (pin_oe),
      .cell_q     (cell_q),
      .pin_out    (pin_out)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic host_write(input logic [7:0] a, input logic [7:0] v);
      host_addr = a; host_wdata = v; host_wr = 1'b1;
      tick();
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [7:0] a);
      host_addr = a; host_rd = 1'b1;
      tick();
      host_rd = 1'b0;
   endtask

   task automatic clear_logic();
      lg_d = '0; lg_en = '0; lg_set = '0; lg_clr = '0;
   endtask

   task automatic t_reset();
      repeat (3) tick();
      check("R1 cells in reset", cell_q, 16'h0000);
      check("R1 pins in reset", pin_out, 16'h0000);
      por_n = 1'b1;
      tick();
      check("R1 cells after release", cell_q, 16'h0000);
   endtask

   task automatic t_host_write();
      host_write(8'h20, 8'hA5);
      check("R3 group at 20h", cell_q, 16'h00A5);
      host_write(8'h21, 8'h3C);
      check("R3 group at 21h", cell_q, 16'h3CA5);
      host_write(8'h1F, 8'hFF);
      check("R11 write below window", cell_q, 16'h3CA5);
      host_write(8'h22, 8'hFF);
      check("R11 write above window", cell_q, 16'h3CA5);
   endtask

   task automatic t_read();
      host_read(8'h20);
      check("R8 read 20h", {8'h00, host_rdata}, 16'h00A5);
      host_read(8'h21);
      check("R8 read 21h", {8'h00, host_rdata}, 16'h003C);
      host_read(8'h22);
      check("R9 read other data", {8'h00, host_rdata}, 16'h0000);
      check("R9 read other no side effect", cell_q, 16'h3CA5);
      // R8: read uses state before a same-edge write
      host_addr = 8'h20; host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'h11;
      tick();
      host_rd = 1'b0; host_wr = 1'b0;
      check("R8 read sees old state", {8'h00, host_rdata}, 16'h00A5);
      check("R3 write alongside read", cell_q, 16'h3C11);
   endtask

   task automatic t_logic();
      host_write(8'h20, 8'h00);
      host_write(8'h21, 8'h00);
      lg_set = 16'h0101; lg_clr = 16'h0101;
      tick();
      check("R5 set over clear", cell_q, 16'h0101);
      clear_logic();
      lg_clr = 16'h0303; lg_en = 16'h0303; lg_d = 16'hFFFF;
      tick();
      check("R6 clear over capture", cell_q, 16'h0000);
      clear_logic();
      lg_d = 16'hFFFF; lg_en = 16'h00F0; lg_clr = 16'h0010;
      tick();
      check("R7 capture ones", cell_q, 16'h00E0);
      clear_logic();
      lg_d = 16'hFFFF;
      tick();
      check("R7 hold without enable", cell_q, 16'h00E0);
      clear_logic();
      lg_en = 16'h0020;
      tick();
      check("R7 capture zero", cell_q, 16'h00C0);
      clear_logic();
   endtask

   task automatic t_priority();
      lg_set = 16'hFFFF;
      host_write(8'h20, 8'h00);
      clear_logic();
      check("R4 load beats set, other group set", cell_q, 16'hFF00);
      lg_clr = 16'hFFFF; lg_en = 16'hFFFF; lg_d = 16'hFFFF;
      host_write(8'h21, 8'h81);
      clear_logic();
      check("R4 load beats clear, other group cleared", cell_q, 16'h8100);
   endtask

   task automatic t_pin_mask();
      host_write(8'h20, 8'hFF);
      host_write(8'h21, 8'hFF);
      pin_oe = 16'h0F0F;
      #1;
      check("R10 masked pins", pin_out, 16'h0F0F);
      pin_oe = 16'hFFFF;
      #1;
      check("R10 all pins enabled", pin_out, 16'hFFFF);
   endtask

   task automatic t_warm();
      host_write(8'h20, 8'hA5);
      host_write(8'h21, 8'h5A);
      host_read(8'h20);
      check("R8 read before warm reset", {8'h00, host_rdata}, 16'h00A5);
      warm_rst_n = 1'b0;
      repeat (3) tick();
      check("R2 cells kept in warm reset", cell_q, 16'h5AA5);
      check("R2 read data cleared", {8'h00, host_rdata}, 16'h0000);
      warm_rst_n = 1'b1;
      tick();
      check("R2 cells kept after warm reset", cell_q, 16'h5AA5);
      #1 por_n = 1'b0;
      #1;
      check("R1 asynchronous clear", cell_q, 16'h0000);
      check("R1 pins cleared", pin_out, 16'h0000);
      tick();
      por_n = 1'b1;
      tick();
   endtask

   initial begin
      tick();
      t_reset();
      t_host_write();
      t_read();
      t_logic();
      t_priority();
      t_pin_mask();
      t_warm();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule